// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one data character into a serial frame and drives it onto a single line. The frame format is chosen at run time. The character holds 5 to 9 data bits. Parity can be off, even or odd. The frame ends with one or two stop bits. Together these give 30 formats. The line rests high when there is nothing to send. A frame always opens with a low start bit. The data follows least significant bit first, then the optional parity bit, then the stop bits.

Each bit lasts one pacing step, and the step comes from one of two sources. In asynchronous mode it is a one-cycle baud tick supplied from outside. In synchronous mode it is an external shift clock. A polarity input picks which edge of that clock moves the line. A one-entry holding register accepts the next character while the current frame is still on the line. The next frame then starts directly after the last stop bit. A one-cycle completion pulse marks the end of a burst.

The format inputs are sampled when a frame starts. The complete frame is built at that moment, so later changes to the format inputs cannot disturb a frame that is already on the line.

Top module: `sfrm_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1. Out of reset, `busy` and `tx_done` are 0.
- R2: Every frame begins with one start bit of value 0. The data bits follow, LSB first. `width_sel` sets the count: codes 0, 1, 2, 3 and 4 give 5, 6, 7, 8 and 9 bits, and codes 5 to 7 also give 9 bits. Bits of `data_in` above the chosen width are not sent.
- R3: `par_sel` sets parity. Code 0 means no parity bit, code 1 even, code 2 odd, and code 3 also means no parity bit. With even parity, the parity bit makes the count of ones over the data bits and the parity bit even. With odd parity, it makes that count odd. The parity bit comes after the last data bit.
- R4: When `two_stop` is 0 the frame ends with one stop bit, and when it is 1 it ends with two. Stop bits are 1.
- R5: When `sync_mode` is 0, `txd` changes only in the clock cycle after a cycle in which `baud_tick` was high. Each bit therefore lasts one tick period.
- R6: When `sync_mode` is 1, `txd` changes only in response to the active edge of `sclk`. With `pol` at 0 the active edge is the rising edge, and with `pol` at 1 it is the falling edge. `txd` changes 3 clock cycles after `sclk` makes that edge.
- R7: A `load` pulse is accepted only while `busy` is 0. `busy` is 1 from the cycle after an accepted load until the frame for that character starts. A `load` while `busy` is 1 is ignored and produces no frame.
- R8: If a character is waiting when the last stop bit ends, its start bit follows at once, with no idle bit in between.
- R9: `tx_done` is high for exactly one clock cycle, one cycle after the step that ends the last stop bit, and only if no character is waiting. It stays low between frames sent back to back.
- R10: The format inputs are sampled at the step that starts a frame. Changing them afterwards has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 1 | 0: pace by `baud_tick`; 1: pace by `sclk` |
| pol | input | 1 | Active `sclk` edge: 0 rising, 1 falling |
| sclk | input | 1 | Shift clock for synchronous mode, sampled in `clk` |
| baud_tick | input | 1 | One-cycle pacing pulse for asynchronous mode |
| load | input | 1 | Strobe that writes `data_in` into the holding register |
| data_in | input | 9 | Character to send |
| width_sel | input | 3 | Data width code |
| par_sel | input | 2 | Parity code |
| two_stop | input | 1 | Stop bit count: 0 one, 1 two |
| txd | output | 1 | Serial line |
| busy | output | 1 | Holding register occupied |
| tx_done | output | 1 | One-cycle end-of-transmission pulse |

## Verification
The results arrive at these times:
- `busy` rises one cycle after an accepted load.
- A new line value appears one cycle after a baud tick, or three cycles after the active edge of `sclk`.
- `tx_done` rises one cycle after the step that ends the last stop bit.

The bench does not sample the line at the step itself. It finds the start bit, then samples every later bit in the middle of its period, so a fixed latency of a few cycles cannot shift a sample into the wrong bit. Bit periods are 8 or 16 cycles.

The exact timing is checked as distances between events. Start-to-start spacing in a burst must equal the frame length times the bit period. The time from a frame's start to `tx_done` must also equal the frame length times the bit period. For synchronous mode, every change of `txd` must happen while `sclk` still holds the level just after its active edge.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

  localparam int DATA_MAX  = 9;
  localparam int DATA_MIN  = 5;
  localparam int STOP_MAX  = 2;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + STOP_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } par_e;

  typedef struct packed {
    logic [2:0] wsel;
    par_e       par;
    logic       two;
  } fmt_t;

  // number of data bits for a width code
  function automatic int data_bits(logic [2:0] wsel);
    return (wsel >= 3'd4) ? DATA_MAX : DATA_MIN + int'(wsel);
  endfunction

  function automatic logic par_on(par_e p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  // parity over the selected data bits
  function automatic logic par_bit(logic [DATA_MAX-1:0] d, logic [2:0] wsel, par_e p);
    logic acc;
    int   n;
    acc = (p == PAR_ODD);
    n   = data_bits(wsel);
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) acc = acc ^ d[i];
    end
    return acc;
  endfunction

  // total bits of one frame: start, data, parity, stops
  function automatic logic [CNT_W-1:0] frame_len(fmt_t f);
    int n;
    n = 1 + data_bits(f.wsel) + (par_on(f.par) ? 1 : 0) + (f.two ? 2 : 1);
    return CNT_W'(n);
  endfunction

  // full frame image, bit 0 goes first; unused upper bits stay high
  function automatic logic [FRAME_MAX-1:0] build_frame(logic [DATA_MAX-1:0] d, fmt_t f);
    logic [FRAME_MAX-1:0] fr;
    int n;
    fr    = '1;
    fr[0] = 1'b0;
    n     = data_bits(f.wsel);
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < n) fr[i+1] = d[i];
    end
    if (par_on(f.par)) fr[n+1] = par_bit(d, f.wsel, f.par);
    return fr;
  endfunction

endpackage

// File: rtl/sfrm_pace.sv
module sfrm_pace #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic pol,
  input  logic sclk,
  input  logic baud_tick,
  output logic step
);

  logic sc_now;
  logic sc_prev;

  if (SYNC_STAGES > 0) begin : g_sync
    logic [SYNC_STAGES:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[SYNC_STAGES-1:0], sclk};
    end
    assign sc_now  = sr[SYNC_STAGES-1];
    assign sc_prev = sr[SYNC_STAGES];
  end else begin : g_direct
    logic d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= 1'b0;
      else        d_q <= sclk;
    end
    assign sc_now  = sclk;
    assign sc_prev = d_q;
  end

  logic sc_rise;
  logic sc_fall;
  assign sc_rise = sc_now & ~sc_prev;
  assign sc_fall = ~sc_now & sc_prev;

  assign step = sync_mode ? (pol ? sc_fall : sc_rise) : baud_tick;

endmodule

// File: rtl/sfrm_hold.sv
module sfrm_hold #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dout <= '0;
    end else if (load && !full) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/sfrm_shift.sv
module sfrm_shift
  import sfrm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                pend,
  input  logic [DATA_MAX-1:0] pend_data,
  input  fmt_t                fmt,
  output logic                start_ev,
  output logic                last_ev,
  output logic                active,
  output logic                txd,
  output logic                done
);

  logic [FRAME_MAX-1:0] sh;
  logic [CNT_W-1:0]     cnt;

  assign active   = (cnt != '0);
  assign last_ev  = step && (cnt == CNT_W'(1));
  assign start_ev = step && pend && ((cnt == '0) || (cnt == CNT_W'(1)));
  assign txd      = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_ev && !pend;
      if (start_ev) begin
        sh  <= build_frame(pend_data, fmt);
        cnt <= frame_len(fmt);
      end else if (step && active) begin
        sh  <= {1'b1, sh[FRAME_MAX-1:1]};
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sfrm_tx.sv
module sfrm_tx
  import sfrm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_mode,
  input  logic                pol,
  input  logic                sclk,
  input  logic                baud_tick,
  input  logic                load,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic [2:0]          width_sel,
  input  logic [1:0]          par_sel,
  input  logic                two_stop,
  output logic                txd,
  output logic                busy,
  output logic                tx_done
);

  logic                step;
  logic                hold_full;
  logic [DATA_MAX-1:0] pend_data;
  logic                frm_start;
  logic                frm_last;
  logic                frm_active;
  fmt_t                fmt_live;

  assign fmt_live = '{wsel: width_sel, par: par_e'(par_sel), two: two_stop};

  sfrm_pace #(.SYNC_STAGES(SYNC_STAGES)) pace_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .pol       (pol),
    .sclk      (sclk),
    .baud_tick (baud_tick),
    .step      (step)
  );

  sfrm_hold #(.W(DATA_MAX)) hold_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .pop   (frm_start),
    .din   (data_in),
    .full  (hold_full),
    .dout  (pend_data)
  );

  sfrm_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .pend      (hold_full),
    .pend_data (pend_data),
    .fmt       (fmt_live),
    .start_ev  (frm_start),
    .last_ev   (frm_last),
    .active    (frm_active),
    .txd       (txd),
    .done      (tx_done)
  );

  assign busy = hold_full;

endmodule

// File: rtl/sfrm_tx_chk.sv
module sfrm_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic busy,
  input logic tx_done,
  input logic load,
  input logic step,
  input logic frm_start,
  input logic frm_last,
  input logic frm_active,
  input logic hold_full
);

  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_active |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |=> !txd);

  a_r5_change_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(step));

  a_r7_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> busy);

  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_last && hold_full) |=> (!txd && frm_active));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> ($past(frm_last) && !frm_active));

endmodule

bind sfrm_tx sfrm_tx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .txd        (txd),
  .busy       (busy),
  .tx_done    (tx_done),
  .load       (load),
  .step       (step),
  .frm_start  (frm_start),
  .frm_last   (frm_last),
  .frm_active (frm_active),
  .hold_full  (hold_full)
);

// File: tb/sfrm_tx_tb_top.sv
module sfrm_tx_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, sync_mode, pol, sclk, baud_tick, load, two_stop;
  logic [8:0] data_in;
  logic [2:0] width_sel;
  logic [1:0] par_sel;
  logic       txd, busy, tx_done;

  sfrm_tx dut_i (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .pol(pol), .sclk(sclk),
    .baud_tick(baud_tick), .load(load), .data_in(data_in), .width_sel(width_sel),
    .par_sel(par_sel), .two_stop(two_stop), .txd(txd), .busy(busy), .tx_done(tx_done)
  );

  typedef struct {
    logic [8:0] d;
    int         w;
    int         par;
    int         two;
  } item_t;

  int    total = 0, bad = 0, cyc = 0, bitp = 8;
  int    done_cnt = 0, done_t = 0, edge_seen = 0, edge_bad = 0;
  bit    tick_en = 0, sclk_en = 0;
  item_t q[$];
  int    starts[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flen(item_t it);
    return 1 + it.w + ((it.par != 0) ? 1 : 0) + ((it.two != 0) ? 2 : 1);
  endfunction

  // baud tick generator
  initial begin
    int tc;
    tc = 0;
    baud_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (tick_en) begin
        baud_tick = (tc == bitp - 1);
        tc = (tc == bitp - 1) ? 0 : tc + 1;
      end else begin
        baud_tick = 1'b0;
        tc = 0;
      end
    end
  end

  // shift clock generator
  initial begin
    int sc;
    sc = 0;
    sclk = 1'b0;
    forever begin
      @(negedge clk);
      if (sclk_en) begin
        sc++;
        if (sc >= bitp / 2) begin
          sc = 0;
          sclk = ~sclk;
        end
      end else begin
        sc = 0;
      end
    end
  end

  // completion pulse counter and edge-relation watcher
  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && tx_done === 1'b1) done_cnt++;
      if (rst_n === 1'b1 && sync_mode === 1'b1 && txd !== prev) begin
        edge_seen++;
        if (sclk !== ~pol) edge_bad++;
      end
      prev = txd;
    end
  end

  // monitor: decodes frames on the line and compares with the scoreboard
  initial begin
    item_t it;
    logic  eb [13];
    string tg [13];
    int    n, ones;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        starts.push_back(cyc);
        repeat (bitp / 2) @(negedge clk);
        if (q.size() == 0) begin
          chk(0, "R7 unexpected frame", 1, 0);
          repeat (bitp * 14) @(negedge clk);
        end else begin
          it = q.pop_front();
          n = flen(it);
          eb[0] = 1'b0; tg[0] = "R2 start bit";
          ones = 0;
          for (int i = 0; i < it.w; i++) begin
            eb[1+i] = it.d[i];
            tg[1+i] = "R2 data bit";
            ones += int'(it.d[i]);
          end
          if (it.par != 0) begin
            eb[1+it.w] = (it.par == 1) ? ones[0] : ~ones[0];
            tg[1+it.w] = "R3 parity bit";
          end
          for (int k = n - ((it.two != 0) ? 2 : 1); k < n; k++) begin
            eb[k] = 1'b1;
            tg[k] = "R4 stop bit";
          end
          for (int k = 0; k < n; k++) begin
            if (k > 0) repeat (bitp) @(negedge clk);
            chk(txd === eb[k], tg[k], int'(txd), int'(eb[k]));
          end
        end
      end
    end
  end

  task automatic send(input logic [8:0] d, input int wc, input int pc, input int ts);
    item_t it;
    while (busy !== 1'b0) @(negedge clk);
    data_in = d; width_sel = 3'(wc); par_sel = 2'(pc); two_stop = ts[0]; load = 1'b1;
    it.d = d;
    it.w = (wc >= 4) ? 9 : wc + 5;
    it.par = (pc == 1) ? 1 : (pc == 2) ? 2 : 0;
    it.two = ts;
    q.push_back(it);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (tx_done !== 1'b1) @(negedge clk);
    done_t = cyc;
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0, s0, k;
    rst_n = 1'b0; sync_mode = 1'b0; pol = 1'b0; load = 1'b0; two_stop = 1'b0;
    data_in = '0; width_sel = '0; par_sel = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    chk(tx_done === 1'b0, "R1 reset done", int'(tx_done), 0);

    // all 30 formats, asynchronous pacing
    tick_en = 1; bitp = 8;
    d0 = done_cnt; k = 0;
    for (int wc = 0; wc < 5; wc++)
      for (int pc = 0; pc < 3; pc++)
        for (int ts = 0; ts < 2; ts++) begin
          send(9'(9'h1A5 ^ (k * 37)), wc, pc, ts);
          wait_done();
          k++;
        end
    chk(done_cnt - d0 == 30, "R9 one pulse per frame", done_cnt - d0, 30);
    chk(txd === 1'b1, "R1 idle high", int'(txd), 1);

    // load while busy is ignored
    tick_en = 0;
    repeat (3) @(negedge clk);
    send(9'h0F3, 3, 1, 0);
    chk(busy === 1'b1, "R7 busy after load", int'(busy), 1);
    data_in = 9'h155; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(busy === 1'b1, "R7 busy held", int'(busy), 1);
    tick_en = 1;
    wait_done();
    repeat (bitp * 16) @(negedge clk);
    chk(q.size() == 0, "R7 scoreboard drained", q.size(), 0);

    // back-to-back burst
    s0 = starts.size(); d0 = done_cnt;
    send(9'h0C6, 3, 0, 0);
    send(9'h05B, 2, 1, 1);
    send(9'h1E1, 4, 2, 0);
    wait_done();
    repeat (10) @(negedge clk);
    chk(starts[s0+1] - starts[s0] == 10 * bitp, "R8 gap after frame 1",
        starts[s0+1] - starts[s0], 10 * bitp);
    chk(starts[s0+2] - starts[s0+1] == 11 * bitp, "R8 gap after frame 2",
        starts[s0+2] - starts[s0+1], 11 * bitp);
    chk(done_cnt - d0 == 1, "R9 single pulse per burst", done_cnt - d0, 1);
    chk(done_t - starts[s0+2] == 12 * bitp, "R5 frame duration",
        done_t - starts[s0+2], 12 * bitp);

    // format change mid-frame
    s0 = starts.size();
    send(9'h0A5, 3, 2, 1);
    while (busy !== 1'b0) @(negedge clk);
    repeat (bitp) @(negedge clk);
    width_sel = 3'd0; par_sel = 2'd0; two_stop = 1'b0; data_in = 9'h000;
    wait_done();
    chk(done_t - starts[s0] == 12 * bitp, "R10 latched length", done_t - starts[s0], 12 * bitp);

    // synchronous pacing, rising edge
    tick_en = 0; sync_mode = 1; pol = 0; bitp = 16;
    repeat (4) @(negedge clk);
    edge_seen = 0; edge_bad = 0;
    sclk_en = 1;
    send(9'h1C3, 6, 3, 0);
    send(9'h02D, 1, 1, 1);
    wait_done();
    chk(edge_bad == 0 && edge_seen > 0, "R6 rising edge", edge_bad, 0);

    // synchronous pacing, falling edge
    sclk_en = 0;
    repeat (20) @(negedge clk);
    pol = 1;
    repeat (6) @(negedge clk);
    edge_seen = 0; edge_bad = 0;
    sclk_en = 1;
    send(9'h133, 5, 2, 1);
    send(9'h0E8, 0, 1, 0);
    wait_done();
    chk(edge_bad == 0 && edge_seen > 0, "R6 falling edge", edge_bad, 0);
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R2 all frames seen", q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule